// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block sits beside a small microcontroller core and manages its low-power states. The core reports each executed instruction on a strobe with a two-bit class code. Power-down is entered only by a two-step sequence: an arm instruction immediately followed by one of two enter instructions. In clock-operating mode the core clock stops but the sub-clock domain keeps running. That domain holds the sub-clock oscillator, the slow timer and the display. In RAM-keep mode the core clock stops and the sub-clock domain stops too, so only RAM and reset logic stay alive.

A warm start returns the core to the reset vector and sets a persistent warm flag. It is caused by an external wakeup in either mode, or by a slow-timer underflow in clock-operating mode only. A cold start clears the warm flag, so software can tell the two apart. It is caused by the reset pin, a watchdog reset or a voltage-drop reset, in any state. A second flag marks a warm start caused by the slow timer. While powered down, the block also overrides the shared counter pin.

All interfaces are plain control signals. The block carries no data stream, so there is no valid/ready handshake and no back-pressure. Wakeup and reset sources are asynchronous and pass through two-flop synchronizers.

Top module: `pwrdn_seq`

## Requirements
- R1: After `rst_n` is released, the block is running: `pd_active`=0, `cpu_clk_en`=1, `subclk_en`=1, `lcd_keep`=1, `warm_flag`=0, `t5_wake_flag`=0.
- R2: The instruction class codes are 00 = other, 01 = arm, 10 = enter clock-operating mode, 11 = enter RAM-keep mode. If an arm is followed on the very next `op_valid` strobe by code 10, the block enters clock-operating mode: `pd_active`=1, `cpu_clk_en`=0, `subclk_en`=1, `lcd_keep`=1.
- R3: If an arm is followed on the very next `op_valid` strobe by code 11, the block enters RAM-keep mode: `pd_active`=1, `cpu_clk_en`=0, `subclk_en`=0, `lcd_keep`=0.
- R4: An enter code has no effect unless the instruction executed just before it was an arm. Any other executed instruction clears the arm latch, and so does any cold-start source.
- R5: `sp_set7` pulses high for exactly one cycle on each entry into power-down. This forces the stack pointer to 7.
- R6: A warm start returns the block to running, raises `restart`, and sets `warm_flag` to 1. `ext_wake` causes a warm start from either mode. `t5_unf` causes one only from clock-operating mode; in RAM-keep mode it is ignored. A warm start holds `restart` high for exactly one cycle.
- R7: `t5_wake_flag` is set when a warm start from clock-operating mode coincides with `t5_unf`. It is cleared by a cold start and by the next entry into power-down.
- R8: Any of `rst_pin`, `wdt_rst` or `vdrop_rst` causes a cold start in every state. The block returns to running, raises `restart` while the source is held, and clears `warm_flag`. A cold start wins over a simultaneous warm-start source.
- R9: While powered down with `cntr_mode`=11, `cntr_oe`=0 and `cntr_ie`=1. While powered down with any other mode, `cntr_oe`=1 and `cntr_out`=0. While running, `cntr_oe` and `cntr_out` follow the core's values.
- R10: While running, `ext_wake` and `t5_unf` have no effect: there is no restart and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset of the block, active low, asynchronous |
| op_valid | input | 1 | Core executed an instruction this cycle |
| op_code | input | 2 | Class of executed instruction (see R2) |
| ext_wake | input | 1 | External wakeup request, asynchronous |
| t5_unf | input | 1 | Slow-timer underflow, asynchronous |
| rst_pin | input | 1 | Reset pin request, asynchronous, active high |
| wdt_rst | input | 1 | Watchdog reset request, asynchronous |
| vdrop_rst | input | 1 | Voltage-drop reset request, asynchronous |
| cntr_mode | input | 2 | Counter pin mode bits; 11 selects input |
| cntr_core_out | input | 1 | Counter pin level from the core |
| cntr_core_oe | input | 1 | Counter pin output enable from the core |
| pd_active | output | 1 | Powered down (either mode) |
| cpu_clk_en | output | 1 | Core clock gate enable |
| subclk_en | output | 1 | Sub-clock oscillator and slow-timer enable |
| lcd_keep | output | 1 | Display allowed to stay on |
| restart | output | 1 | Force core to address 0 of page 0 |
| sp_set7 | output | 1 | Load stack pointer with 7 |
| warm_flag | output | 1 | Warm-start flag readable by software |
| t5_wake_flag | output | 1 | Warm start caused by slow timer |
| cntr_out | output | 1 | Counter pin output level |
| cntr_oe | output | 1 | Counter pin output enable |
| cntr_ie | output | 1 | Counter pin input enable |

## Verification
Some rules are checked by properties on every cycle:
- a cold source always lands in running with the warm flag cleared;
- an unarmed enter never leaves running;
- RAM-keep mode ignores the slow timer;
- the stack-pointer pulse only appears in power-down;
- the counter pin is never driven while in input mode during power-down.

Other behaviour needs the bench's scenarios. This covers how long the warm flag persists across a sequence of sleeps, how the timer-wake flag is cleared on re-entry, that an arm is lost to an intervening instruction or reset, and how many restart and stack-pointer pulses appear.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PDCLK = 2'd1,
    ST_PDRAM = 2'd2
  } pd_state_e;

  localparam logic [1:0] OP_OTHER = 2'b00;
  localparam logic [1:0] OP_ARM   = 2'b01;
  localparam logic [1:0] OP_CLK   = 2'b10;
  localparam logic [1:0] OP_RAM   = 2'b11;
  localparam logic [1:0] CNTR_IN  = 2'b11;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pd_arm.sv
module pd_arm
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pd_state_e st,
  input  logic      op_valid,
  input  logic [1:0] op_code,
  input  logic      cold_s,
  output logic      arm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          arm_q <= 1'b0;
    else if (cold_s)                     arm_q <= 1'b0;
    else if (st == ST_RUN && op_valid)   arm_q <= (op_code == OP_ARM);
  end

  // R4
  arm_cleared_by_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cold_s |=> !arm_q);
endmodule

// File: rtl/pd_core.sv
module pd_core
  import pd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [1:0] op_code,
  input  logic       arm_q,
  input  logic       wake_s,
  input  logic       t5_s,
  input  logic       cold_s,
  output pd_state_e  st,
  output logic       p_flag,
  output logic       t5_flag,
  output logic       restart,
  output logic       sp_set
);
  logic warm_go, enter_go;

  always_comb begin
    warm_go  = ((st == ST_PDCLK) && (wake_s || t5_s)) ||
               ((st == ST_PDRAM) && wake_s);
    enter_go = (st == ST_RUN) && op_valid && op_code[1] && arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RUN;
      p_flag  <= 1'b0;
      t5_flag <= 1'b0;
      restart <= 1'b0;
      sp_set  <= 1'b0;
    end else begin
      restart <= cold_s || warm_go;
      sp_set  <= enter_go && !cold_s;
      if (cold_s) begin
        st      <= ST_RUN;
        p_flag  <= 1'b0;
        t5_flag <= 1'b0;
      end else if (warm_go) begin
        st      <= ST_RUN;
        p_flag  <= 1'b1;
        t5_flag <= (st == ST_PDCLK) && t5_s;
      end else if (enter_go) begin
        st      <= op_code[0] ? ST_PDRAM : ST_PDCLK;
        t5_flag <= 1'b0;
      end
    end
  end

  // R8
  cold_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cold_s |=> (st == ST_RUN && !p_flag && restart));
  // R4
  unarmed_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && op_valid && op_code[1] && !arm_q) |=> (st == ST_RUN));
  // R6
  ram_ignores_t5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PDRAM && t5_s && !wake_s && !cold_s) |=> (st == ST_PDRAM));
  // R6
  warm_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN && wake_s && !cold_s) |=> (p_flag && restart && st == ST_RUN));
  // R5
  sp_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_set |-> (st != ST_RUN));
  // R10
  run_ignores_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !cold_s) |=> !restart);
endmodule

// File: rtl/pd_pins.sv
module pd_pins
  import pd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd,
  input  logic [1:0] mode,
  input  logic       core_out,
  input  logic       core_oe,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       pin_ie
);
  always_comb begin
    pin_ie  = (mode == CNTR_IN);
    pin_oe  = pd ? (mode != CNTR_IN) : core_oe;
    pin_out = pd ? 1'b0 : core_out;
  end

  // R9
  pin_input_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && mode == CNTR_IN) |-> (!pin_oe && pin_ie));
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [1:0] op_code,
  input  logic       ext_wake,
  input  logic       t5_unf,
  input  logic       rst_pin,
  input  logic       wdt_rst,
  input  logic       vdrop_rst,
  input  logic [1:0] cntr_mode,
  input  logic       cntr_core_out,
  input  logic       cntr_core_oe,
  output logic       pd_active,
  output logic       cpu_clk_en,
  output logic       subclk_en,
  output logic       lcd_keep,
  output logic       restart,
  output logic       sp_set7,
  output logic       warm_flag,
  output logic       t5_wake_flag,
  output logic       cntr_out,
  output logic       cntr_oe,
  output logic       cntr_ie
);
  localparam int NSRC = 5;

  logic [NSRC-1:0] src_a, src_s;
  logic            cold_s, arm_q;
  pd_state_e       st;

  assign src_a  = {vdrop_rst, wdt_rst, rst_pin, t5_unf, ext_wake};
  assign cold_s = |src_s[4:2];

  pd_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_a), .q(src_s)
  );

  pd_arm u_arm (
    .clk(clk), .rst_n(rst_n), .st(st), .op_valid(op_valid),
    .op_code(op_code), .cold_s(cold_s), .arm_q(arm_q)
  );

  pd_core u_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .arm_q(arm_q), .wake_s(src_s[0]), .t5_s(src_s[1]), .cold_s(cold_s),
    .st(st), .p_flag(warm_flag), .t5_flag(t5_wake_flag),
    .restart(restart), .sp_set(sp_set7)
  );

  always_comb begin
    pd_active  = (st != ST_RUN);
    cpu_clk_en = (st == ST_RUN);
    subclk_en  = (st != ST_PDRAM);
    lcd_keep   = (st != ST_PDRAM);
  end

  pd_pins u_pins (
    .clk(clk), .rst_n(rst_n), .pd(pd_active), .mode(cntr_mode),
    .core_out(cntr_core_out), .core_oe(cntr_core_oe),
    .pin_out(cntr_out), .pin_oe(cntr_oe), .pin_ie(cntr_ie)
  );

  // R3
  ram_mode_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && !subclk_en) |-> (!lcd_keep && !cpu_clk_en));
endmodule

// File: tb/sim_pwrdn_seq.sv
`timescale 1ns/1ps
module sim_pwrdn_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic ext_wake = 1'b0, t5_unf = 1'b0, rst_pin = 1'b0, wdt_rst = 1'b0, vdrop_rst = 1'b0;
  logic [1:0] cntr_mode = 2'b00;
  logic cntr_core_out = 1'b0, cntr_core_oe = 1'b0;
  logic pd_active, cpu_clk_en, subclk_en, lcd_keep, restart, sp_set7;
  logic warm_flag, t5_wake_flag, cntr_out, cntr_oe, cntr_ie;

  int nchk = 0, nfail = 0;
  int rs_rise = 0, rs_high = 0, sp_cnt = 0;
  logic rs_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwrdn_seq u0 (.*);

  always @(negedge clk) begin
    if (restart && !rs_prev) rs_rise++;
    if (restart) rs_high++;
    if (sp_set7) sp_cnt++;
    rs_prev = restart;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] c);
    @(negedge clk); op_valid = 1'b1; op_code = c;
    @(negedge clk); op_valid = 1'b0; op_code = 2'b00;
  endtask

  task automatic two_ops(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk); op_valid = 1'b1; op_code = a;
    @(negedge clk); op_code = b;
    @(negedge clk); op_valid = 1'b0; op_code = 2'b00;
    @(negedge clk);
  endtask

  // ev: 0 none, 1 ext wake, 2 slow timer, 3 reset pin
  task automatic event_pulse(input logic [1:0] ev);
    @(negedge clk);
    ext_wake = (ev == 2'd1); t5_unf = (ev == 2'd2); rst_pin = (ev == 2'd3);
    repeat (4) @(negedge clk);
    ext_wake = 1'b0; t5_unf = 1'b0; rst_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // {op1[10:9], op2[8:7], ev[6:5], pd_ent[4], pd_aft[3], p[2], t5[1], sub[0]}
  localparam int NV = 9;
  localparam logic [10:0] VEC [NV] = '{
    {2'b01, 2'b10, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'b01, 2'b11, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'b01, 2'b10, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b00, 2'b10, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'b01, 2'b11, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b10, 2'b11, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {2'b01, 2'b11, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'b01, 2'b00, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'b01, 2'b10, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    int r0, s0, h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pd_active", pd_active, 0);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 subclk_en", subclk_en, 1);
    chk("R1 lcd_keep", lcd_keep, 1);
    chk("R1 warm_flag", warm_flag, 0);
    chk("R1 t5_wake_flag", t5_wake_flag, 0);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      r0 = rs_rise; s0 = sp_cnt;
      two_ops(v[10:9], v[8:7]);
      chk($sformatf("R2 R3 R4 v%0d entered", i), pd_active, v[4]);
      chk($sformatf("R2 R3 v%0d subclk_en", i), subclk_en, v[0]);
      chk($sformatf("R3 v%0d lcd_keep", i), lcd_keep, v[0]);
      chk($sformatf("R2 v%0d cpu_clk_en", i), cpu_clk_en, !v[4]);
      chk($sformatf("R5 v%0d sp pulses", i), sp_cnt - s0, v[4]);
      event_pulse(v[6:5]);
      chk($sformatf("R6 R8 R10 v%0d pd after event", i), pd_active, v[3]);
      chk($sformatf("R6 R8 v%0d warm_flag", i), warm_flag, v[2]);
      chk($sformatf("R7 v%0d t5_wake_flag", i), t5_wake_flag, v[1]);
      chk($sformatf("R6 R8 R10 v%0d restarts", i), rs_rise - r0,
          (v[6:5] == 2'd3 || (v[4] && !v[3])) ? 1 : 0);
      if (pd_active) event_pulse(2'd1);
    end

    // R6: warm restart lasts one cycle
    two_ops(2'b01, 2'b10);
    h0 = rs_high;
    event_pulse(2'd1);
    chk("R6 restart width", rs_high - h0, 1);

    // R8: cold beats simultaneous warm
    two_ops(2'b01, 2'b10);
    @(negedge clk); ext_wake = 1'b1; vdrop_rst = 1'b1;
    repeat (4) @(negedge clk); ext_wake = 1'b0; vdrop_rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 cold priority pd", pd_active, 0);
    chk("R8 cold priority flag", warm_flag, 0);

    // R8: watchdog from running
    event_pulse(2'd1);
    r0 = rs_rise;
    @(negedge clk); wdt_rst = 1'b1;
    repeat (4) @(negedge clk); wdt_rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 wdt restart", rs_rise - r0, 1);

    // R4: arm lost to a cold reset
    op(2'b01);
    @(negedge clk); wdt_rst = 1'b1;
    repeat (4) @(negedge clk); wdt_rst = 1'b0;
    repeat (4) @(negedge clk);
    op(2'b10);
    @(negedge clk);
    chk("R4 arm cleared by reset", pd_active, 0);

    // R9: counter pin
    cntr_mode = 2'b00; cntr_core_out = 1'b1; cntr_core_oe = 1'b1;
    @(negedge clk);
    chk("R9 run out", cntr_out, 1);
    chk("R9 run oe", cntr_oe, 1);
    two_ops(2'b01, 2'b10);
    chk("R9 pd out low", cntr_out, 0);
    chk("R9 pd oe", cntr_oe, 1);
    cntr_mode = 2'b11;
    @(negedge clk);
    chk("R9 input mode oe", cntr_oe, 0);
    chk("R9 input mode ie", cntr_ie, 1);
    event_pulse(2'd1);
    chk("R9 woke", pd_active, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule